// File: doc/BRIEF.md
# Shared Scratch SRAM Port Arbiter

This block sits in front of a single-ported on-chip scratch SRAM that two requesters share. One requester is a CPU-facing bus slave with separate read-command, write-command, write-data, read-return and write-response channels. The other is an internal DMA engine with a simple request/stall port. Every cycle the block grants the one SRAM port to at most one of them. The CPU slave side always wins over the DMA side.

On the slave side, single-beat reads and writes are ordered round-robin whenever both are pending. A write is only taken once both its command and its data are present, and its response follows one cycle later. A single-entry exclusive monitor lets the CPU perform a load-reserved / store-conditional pair. The conditional write happens, and reports the exclusive-success code, only when no write from either port has touched the reserved word since the reservation was made. The SRAM needs no setup and accepts traffic on the first cycle after reset.

Top module: `sram_port_arb`

## Requirements
- R1: In any cycle at most one slave command is accepted: `s_ar_ready` and `s_aw_ready` are never high together.
- R2: When a slave read (`s_ar_valid`) and a complete slave write (`s_aw_valid` and `s_w_valid`) are both pending, they are served alternately. The first such conflict after reset goes to the read (default `WR_FIRST`=0). After a read is served the next conflict goes to the write, and after a write the next goes to the read.
- R3: A slave write is accepted only in a cycle where command and data are both valid, and `s_aw_ready` equals `s_w_ready`. `s_b_valid` rises exactly one cycle after acceptance, carrying the command's ID.
- R4: An exclusive read (`s_ar_excl`=1) arms the single reservation with its word address and ID, and returns response code 2'b01 (exclusive okay). A normal read returns 2'b00 (okay). A newer exclusive read replaces the reservation.
- R5: An exclusive write whose address and ID match an armed reservation is performed and answers 2'b01, and it disarms the reservation. Any other exclusive write (no reservation, or a different ID or address) is not performed and answers 2'b00. A normal write always answers 2'b00.
- R6: Any performed write to the reserved word, from either port, disarms the reservation. Writes to other words leave it armed.
- R7: While a slave read or complete slave write is pending, the DMA request is not served and `d_stall` equals `d_req`. The DMA engine holds its request stable until unstalled.
- R8: A DMA request with no slave traffic pending is served in that cycle with `d_stall` low. A DMA write updates the word. A DMA read returns `d_rvalid` with the word one cycle later.
- R9: A slave read returns `s_r_valid` one cycle after `s_ar_ready`, with the request's ID and the last value written to that word by either port.
- R10: During reset `s_r_valid`, `s_b_valid` and `d_rvalid` are low, and the first cycle after reset already accepts traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_ar_valid | input | 1 | Slave read command valid |
| s_ar_ready | output | 1 | Slave read command accepted |
| s_ar_addr | input | ADDR_W | Slave read word address |
| s_ar_id | input | ID_W | Slave read ID |
| s_ar_excl | input | 1 | Slave read is exclusive |
| s_r_valid | output | 1 | Slave read data valid |
| s_r_data | output | DATA_W | Slave read data |
| s_r_id | output | ID_W | Slave read data ID |
| s_r_resp | output | 2 | Read response, 00 okay, 01 exclusive okay |
| s_aw_valid | input | 1 | Slave write command valid |
| s_aw_ready | output | 1 | Slave write command accepted |
| s_aw_addr | input | ADDR_W | Slave write word address |
| s_aw_id | input | ID_W | Slave write ID |
| s_aw_excl | input | 1 | Slave write is exclusive |
| s_w_valid | input | 1 | Slave write data valid |
| s_w_ready | output | 1 | Slave write data accepted |
| s_w_data | input | DATA_W | Slave write data |
| s_b_valid | output | 1 | Write response valid |
| s_b_id | output | ID_W | Write response ID |
| s_b_resp | output | 2 | Write response, 00 okay, 01 exclusive okay |
| d_req | input | 1 | DMA access request |
| d_we | input | 1 | DMA access is a write |
| d_addr | input | ADDR_W | DMA word address |
| d_wdata | input | DATA_W | DMA write data |
| d_stall | output | 1 | DMA request held off by slave traffic |
| d_rvalid | output | 1 | DMA read data valid |
| d_rdata | output | DATA_W | DMA read data |

## Verification
The hardest case to reach is an exclusive write that must fail because a write from the other port slipped in between the reservation and the conditional store. The DMA engine can only reach the SRAM in a cycle with no slave traffic. The bench therefore interleaves deliberate idle slave cycles to let a DMA write to the reserved word land, then issues the exclusive write and reads the word back. Round-robin ordering is reached by holding a read and a complete write valid together over many cycles. A cycle-level model of the grant order predicts which side wins each cycle.

// File: rtl/sram_arb_pkg.sv
package sram_arb_pkg;
   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01
   } resp_e;
endpackage

// File: rtl/sram_rw_arb.sv
module sram_rw_arb #(
   parameter bit WR_FIRST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic wr_req,
   output logic rd_gnt,
   output logic wr_gnt
);
   logic pref_wr;

   always_comb begin
      rd_gnt = rd_req && (!wr_req || !pref_wr);
      wr_gnt = wr_req && (!rd_req ||  pref_wr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pref_wr <= WR_FIRST;
      else if (rd_gnt) pref_wr <= 1'b1;
      else if (wr_gnt) pref_wr <= 1'b0;
   end
endmodule

// File: rtl/sram_excl_mon.sv
module sram_excl_mon #(
   parameter int ADDR_W = 6,
   parameter int ID_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic [ID_W-1:0]   arm_id,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [ID_W-1:0]   chk_id,
   output logic              chk_ok
);
   logic              rsv_vld;
   logic [ADDR_W-1:0] rsv_addr;
   logic [ID_W-1:0]   rsv_id;

   assign chk_ok = rsv_vld && (rsv_addr == chk_addr) && (rsv_id == chk_id);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsv_vld  <= 1'b0;
         rsv_addr <= '0;
         rsv_id   <= '0;
      end else if (arm) begin
         rsv_vld  <= 1'b1;
         rsv_addr <= arm_addr;
         rsv_id   <= arm_id;
      end else if (wr_en && (wr_addr == rsv_addr)) begin
         rsv_vld  <= 1'b0;
      end
   end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/sram_port_arb.sv
module sram_port_arb
   import sram_arb_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 32,
   parameter int ID_W     = 4,
   parameter bit WR_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_ar_valid,
   output logic              s_ar_ready,
   input  logic [ADDR_W-1:0] s_ar_addr,
   input  logic [ID_W-1:0]   s_ar_id,
   input  logic              s_ar_excl,
   output logic              s_r_valid,
   output logic [DATA_W-1:0] s_r_data,
   output logic [ID_W-1:0]   s_r_id,
   output logic [1:0]        s_r_resp,
   input  logic              s_aw_valid,
   output logic              s_aw_ready,
   input  logic [ADDR_W-1:0] s_aw_addr,
   input  logic [ID_W-1:0]   s_aw_id,
   input  logic              s_aw_excl,
   input  logic              s_w_valid,
   output logic              s_w_ready,
   input  logic [DATA_W-1:0] s_w_data,
   output logic              s_b_valid,
   output logic [ID_W-1:0]   s_b_id,
   output logic [1:0]        s_b_resp,
   input  logic              d_req,
   input  logic              d_we,
   input  logic [ADDR_W-1:0] d_addr,
   input  logic [DATA_W-1:0] d_wdata,
   output logic              d_stall,
   output logic              d_rvalid,
   output logic [DATA_W-1:0] d_rdata
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("sram_port_arb: ADDR_W must be within 1..16");
   end
   if (DATA_W < 8 || DATA_W > 1024) begin : g_bad_data_w
      $error("sram_port_arb: DATA_W must be within 8..1024");
   end
   if (ID_W < 1 || ID_W > 16) begin : g_bad_id_w
      $error("sram_port_arb: ID_W must be within 1..16");
   end

   logic              rd_cand, wr_cand, slv_busy;
   logic              rd_gnt, wr_gnt, dma_gnt, excl_ok, slv_wr_do;
   logic              ram_en, ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   assign rd_cand  = s_ar_valid;
   assign wr_cand  = s_aw_valid && s_w_valid;
   assign slv_busy = rd_cand || wr_cand;
   assign dma_gnt  = d_req && !slv_busy;
   assign d_stall  = d_req && slv_busy;

   sram_rw_arb #(.WR_FIRST(WR_FIRST)) u_rw_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_req (rd_cand),
      .wr_req (wr_cand),
      .rd_gnt (rd_gnt),
      .wr_gnt (wr_gnt)
   );

   assign s_ar_ready = rd_gnt;
   assign s_aw_ready = wr_gnt;
   assign s_w_ready  = wr_gnt;
   assign slv_wr_do  = wr_gnt && (!s_aw_excl || excl_ok);

   always_comb begin
      ram_en    = rd_gnt || wr_gnt || dma_gnt;
      ram_we    = slv_wr_do || (dma_gnt && d_we);
      ram_addr  = d_addr;
      ram_wdata = d_wdata;
      if (rd_gnt) begin
         ram_addr = s_ar_addr;
      end else if (wr_gnt) begin
         ram_addr  = s_aw_addr;
         ram_wdata = s_w_data;
      end
   end

   sram_excl_mon #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_excl_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (rd_gnt && s_ar_excl),
      .arm_addr (s_ar_addr),
      .arm_id   (s_ar_id),
      .wr_en    (ram_we),
      .wr_addr  (ram_addr),
      .chk_addr (s_aw_addr),
      .chk_id   (s_aw_id),
      .chk_ok   (excl_ok)
   );

   sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_r_valid <= 1'b0;
         s_r_id    <= '0;
         s_r_resp  <= RESP_OKAY;
         s_b_valid <= 1'b0;
         s_b_id    <= '0;
         s_b_resp  <= RESP_OKAY;
         d_rvalid  <= 1'b0;
      end else begin
         s_r_valid <= rd_gnt;
         s_b_valid <= wr_gnt;
         d_rvalid  <= dma_gnt && !d_we;
         if (rd_gnt) begin
            s_r_id   <= s_ar_id;
            s_r_resp <= s_ar_excl ? RESP_EXOKAY : RESP_OKAY;
         end
         if (wr_gnt) begin
            s_b_id   <= s_aw_id;
            s_b_resp <= (s_aw_excl && excl_ok) ? RESP_EXOKAY : RESP_OKAY;
         end
      end
   end

   assign s_r_data = ram_rdata;
   assign d_rdata  = ram_rdata;
endmodule

// File: rtl/sram_port_arb_chk.sv
module sram_port_arb_chk #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_ar_valid,
   input logic              s_ar_ready,
   input logic              s_r_valid,
   input logic              s_aw_valid,
   input logic              s_aw_ready,
   input logic              s_aw_excl,
   input logic              s_w_valid,
   input logic              s_w_ready,
   input logic              s_b_valid,
   input logic [1:0]        s_b_resp,
   input logic              d_req,
   input logic              d_we,
   input logic [ADDR_W-1:0] d_addr,
   input logic [DATA_W-1:0] d_wdata,
   input logic              d_stall,
   input logic              d_rvalid
);
   AST_ONE_SLAVE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_ar_ready && s_aw_ready)); // R1

   AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ar_valid && s_aw_valid && s_w_valid && $past(s_ar_ready)) |-> s_aw_ready); // R2

   AST_B_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      s_aw_ready |=> s_b_valid); // R3

   AST_B_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      s_b_valid |-> $past(s_w_valid && s_w_ready)); // R3

   AST_EXOK_ONLY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (s_b_valid && s_b_resp == 2'b01) |-> $past(s_aw_excl && s_aw_ready)); // R5

   AST_SLAVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && (s_ar_valid || (s_aw_valid && s_w_valid))) |-> (d_stall && !$past(1'b0))); // R7

   AST_DMA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && d_stall) |=> (d_req && $stable(d_addr) && $stable(d_we) && $stable(d_wdata))); // R7

   AST_DMA_RLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (d_req && !d_stall && !d_we) |=> d_rvalid); // R8

   AST_SLAVE_RLAT: assert property (@(posedge clk) disable iff (!rst_n)
      s_ar_ready |=> s_r_valid); // R9
endmodule

bind sram_port_arb sram_port_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_ar_valid (s_ar_valid),
   .s_ar_ready (s_ar_ready),
   .s_r_valid  (s_r_valid),
   .s_aw_valid (s_aw_valid),
   .s_aw_ready (s_aw_ready),
   .s_aw_excl  (s_aw_excl),
   .s_w_valid  (s_w_valid),
   .s_w_ready  (s_w_ready),
   .s_b_valid  (s_b_valid),
   .s_b_resp   (s_b_resp),
   .d_req      (d_req),
   .d_we       (d_we),
   .d_addr     (d_addr),
   .d_wdata    (d_wdata),
   .d_stall    (d_stall),
   .d_rvalid   (d_rvalid)
);

// File: tb/sram_port_arb_bench.sv
`timescale 1ns/1ps
module sram_port_arb_bench;
   localparam int AW = 6;
   localparam int DW = 32;
   localparam int IW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_ar_valid = 0, s_ar_excl = 0, s_aw_valid = 0, s_aw_excl = 0, s_w_valid = 0;
   logic [AW-1:0] s_ar_addr = '0, s_aw_addr = '0, d_addr = '0;
   logic [IW-1:0] s_ar_id = '0, s_aw_id = '0;
   logic [DW-1:0] s_w_data = '0, d_wdata = '0;
   logic          d_req = 0, d_we = 0;
   logic          s_ar_ready, s_aw_ready, s_w_ready, s_r_valid, s_b_valid, d_stall, d_rvalid;
   logic [DW-1:0] s_r_data, d_rdata;
   logic [IW-1:0] s_r_id, s_b_id;
   logic [1:0]    s_r_resp, s_b_resp;

   always #5 clk = ~clk;

   sram_port_arb #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW)) u_sram_port_arb (.*);

   // next-cycle stimulus, applied at the falling edge
   logic          n_ar_v = 0, n_ar_ex = 0, n_aw_v = 0, n_aw_ex = 0, n_w_v = 0, n_dq = 0, n_dwe = 0;
   logic [AW-1:0] n_ar_a = '0, n_aw_a = '0, n_da = '0;
   logic [IW-1:0] n_ar_id = '0, n_aw_id = '0;
   logic [DW-1:0] n_wd = '0, n_dwd = '0;

   // requirement model
   logic [DW-1:0] em [DEPTH];
   bit            known [DEPTH];
   bit            pref_wr = 0;
   bit            rsv_v = 0;
   logic [AW-1:0] rsv_a = '0;
   logic [IW-1:0] rsv_id = '0;
   bit            e_rv = 0, e_rk = 0, e_bv = 0, e_dv = 0, e_dk = 0;
   logic [DW-1:0] e_rd = '0, e_dd = '0;
   logic [IW-1:0] e_rid = '0, e_bid = '0;
   logic [1:0]    e_rresp = '0, e_bresp = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic chk(string req, string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s [%s] %s act=%0h exp=%0h", req, tag, what, act, exp);
      end
   endtask

   task automatic mwrite(logic [AW-1:0] a, logic [DW-1:0] d);
      em[a] = d;
      known[a] = 1;
      if (rsv_v && rsv_a == a) rsv_v = 0;
   endtask

   task automatic cyc(string tag);
      bit rd_c, wr_c, srd, swr, gnt, ok;
      @(negedge clk);
      chk("R9", tag, "r_valid", 32'(s_r_valid), 32'(e_rv));
      if (e_rv) begin
         chk("R9", tag, "r_id", 32'(s_r_id), 32'(e_rid));
         chk("R4", tag, "r_resp", 32'(s_r_resp), 32'(e_rresp));
         if (e_rk) chk("R9", tag, "r_data", s_r_data, e_rd);
      end
      chk("R3", tag, "b_valid", 32'(s_b_valid), 32'(e_bv));
      if (e_bv) begin
         chk("R3", tag, "b_id", 32'(s_b_id), 32'(e_bid));
         chk("R5", tag, "b_resp", 32'(s_b_resp), 32'(e_bresp));
      end
      chk("R8", tag, "d_rvalid", 32'(d_rvalid), 32'(e_dv));
      if (e_dv && e_dk) chk("R8", tag, "d_rdata", d_rdata, e_dd);
      s_ar_valid = n_ar_v; s_ar_addr = n_ar_a; s_ar_id = n_ar_id; s_ar_excl = n_ar_ex;
      s_aw_valid = n_aw_v; s_aw_addr = n_aw_a; s_aw_id = n_aw_id; s_aw_excl = n_aw_ex;
      s_w_valid = n_w_v; s_w_data = n_wd;
      d_req = n_dq; d_we = n_dwe; d_addr = n_da; d_wdata = n_dwd;
      #1;
      rd_c = n_ar_v;
      wr_c = n_aw_v && n_w_v;
      srd = rd_c && (!wr_c || !pref_wr);
      swr = wr_c && (!rd_c || pref_wr);
      gnt = n_dq && !(rd_c || wr_c);
      chk("R2", tag, "ar_ready", 32'(s_ar_ready), 32'(srd));
      chk("R2", tag, "aw_ready", 32'(s_aw_ready), 32'(swr));
      chk("R3", tag, "w_ready", 32'(s_w_ready), 32'(swr));
      chk("R1", tag, "one_cmd", 32'(s_ar_ready && s_aw_ready), 32'd0);
      chk("R7", tag, "d_stall", 32'(d_stall), 32'(n_dq && (rd_c || wr_c)));
      e_rv = srd; e_bv = swr; e_dv = gnt && !n_dwe;
      if (srd) begin
         e_rd = em[n_ar_a]; e_rk = known[n_ar_a]; e_rid = n_ar_id;
         e_rresp = n_ar_ex ? 2'b01 : 2'b00;
         if (n_ar_ex) begin rsv_v = 1; rsv_a = n_ar_a; rsv_id = n_ar_id; end
         pref_wr = 1;
      end
      if (swr) begin
         ok = rsv_v && rsv_a == n_aw_a && rsv_id == n_aw_id;
         e_bid = n_aw_id;
         e_bresp = (n_aw_ex && ok) ? 2'b01 : 2'b00;
         if (!n_aw_ex || ok) mwrite(n_aw_a, n_wd);
         pref_wr = 0;
      end
      if (gnt) begin
         if (n_dwe) mwrite(n_da, n_dwd);
         else begin e_dd = em[n_da]; e_dk = known[n_da]; end
      end
   endtask

   task automatic idle_all();
      n_ar_v = 0; n_ar_ex = 0; n_aw_v = 0; n_aw_ex = 0; n_w_v = 0; n_dq = 0; n_dwe = 0;
   endtask

   task automatic sread(logic [AW-1:0] a, logic [IW-1:0] id, bit ex, string tag);
      idle_all(); n_ar_v = 1; n_ar_a = a; n_ar_id = id; n_ar_ex = ex;
      cyc(tag);
      idle_all();
   endtask

   task automatic swrite(logic [AW-1:0] a, logic [IW-1:0] id, bit ex, logic [DW-1:0] d, string tag);
      idle_all(); n_aw_v = 1; n_w_v = 1; n_aw_a = a; n_aw_id = id; n_aw_ex = ex; n_wd = d;
      cyc(tag);
      idle_all();
   endtask

   task automatic dwrite(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
      idle_all(); n_dq = 1; n_dwe = 1; n_da = a; n_dwd = d;
      cyc(tag);
      idle_all();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) known[i] = 0;
      repeat (3) @(negedge clk);
      chk("R10", "reset", "r_valid", 32'(s_r_valid), 32'd0);
      chk("R10", "reset", "b_valid", 32'(s_b_valid), 32'd0);
      chk("R10", "reset", "d_rvalid", 32'(d_rvalid), 32'd0);
      rst_n = 1;

      // R10 / R2: first cycle after reset, read and write collide; read goes first
      n_ar_v = 1; n_ar_a = 3; n_ar_id = 1;
      n_aw_v = 1; n_w_v = 1; n_aw_a = 3; n_aw_id = 2;
      for (int k = 0; k < 8; k++) begin
         n_wd = 32'hC0DE_0000 + 32'(k);
         cyc(k == 0 ? "R10" : "R2");
      end
      idle_all();

      // R3: command without data is held off, then taken with data
      n_aw_v = 1; n_aw_a = 7; n_aw_id = 5; n_wd = 32'h7777_0007;
      cyc("R3");
      cyc("R3");
      n_w_v = 1;
      cyc("R3");
      idle_all();

      // sweep: slave writes then reads every word
      for (int a = 0; a < DEPTH; a++)
         swrite(AW'(a), IW'(a), 0, 32'(a) * 32'h0101_0101 ^ 32'h5A00_0000, "R3");
      for (int a = 0; a < DEPTH; a++) sread(AW'(a), IW'(a + 3), 0, "R9");

      // DMA alone writes even words, then reads all
      for (int a = 0; a < DEPTH; a += 2) dwrite(AW'(a), 32'hD000_0000 + 32'(a * 3), "R8");
      for (int a = 0; a < DEPTH; a++) begin
         idle_all(); n_dq = 1; n_da = AW'(a); cyc("R8");
      end
      idle_all();

      // R7: slave read and DMA read collide; DMA holds and is served next
      for (int a = 0; a < DEPTH; a += 4) begin
         idle_all();
         n_ar_v = 1; n_ar_a = AW'(a); n_ar_id = 4'h9;
         n_dq = 1; n_da = AW'(DEPTH - 1 - a);
         cyc("R7");
         n_ar_v = 0;
         cyc("R7");
      end
      // R7: slave write stalls a DMA write to the same word; DMA lands after
      idle_all();
      n_aw_v = 1; n_w_v = 1; n_aw_a = 12; n_aw_id = 1; n_wd = 32'h1111_2222;
      n_dq = 1; n_dwe = 1; n_da = 12; n_dwd = 32'h3333_4444;
      cyc("R7");
      n_aw_v = 0; n_w_v = 0;
      cyc("R7");
      sread(12, 2, 0, "R7");

      // R4 / R5: exclusive pair succeeds once, then fails
      sread(10, 3, 1, "R4");
      swrite(10, 3, 1, 32'hE0E0_0010, "R5");
      swrite(10, 3, 1, 32'hBAD0_0010, "R5");
      sread(10, 0, 0, "R5");
      // R5: ID mismatch fails
      sread(40, 1, 1, "R5");
      swrite(40, 2, 1, 32'hBAD0_0040, "R5");
      sread(40, 0, 0, "R5");
      // R6: DMA write to reserved word breaks reservation
      sread(20, 4, 1, "R6");
      dwrite(20, 32'hD0D0_0020, "R6");
      swrite(20, 4, 1, 32'hBAD0_0020, "R6");
      sread(20, 0, 0, "R6");
      // R6: write to another word keeps reservation
      sread(50, 6, 1, "R6");
      swrite(51, 6, 0, 32'h0000_0051, "R6");
      dwrite(52, 32'h0000_0052, "R6");
      swrite(50, 6, 1, 32'hE0E0_0050, "R6");
      sread(50, 0, 0, "R6");
      // R4: a newer exclusive read replaces the reservation
      sread(30, 5, 1, "R4");
      sread(31, 5, 1, "R4");
      swrite(30, 5, 1, 32'hBAD0_0030, "R4");
      swrite(31, 5, 1, 32'hE0E0_0031, "R4");
      sread(30, 0, 0, "R4");
      sread(31, 0, 0, "R4");

      idle_all();
      cyc("flush");
      cyc("flush");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule